// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is a 12-bit down-counter for a real-time-clock style peripheral. Software programs a preset through a byte-wide write port: one register holds the low eight bits of the preset and a second holds the top four. The counter steps down once per pulse of one of four prescaled tick enables: 4096 Hz, 64 Hz, 1 Hz or once per minute. A two-bit source field chooses the rate.

While the run bit is set, each selected tick lowers the count by one. When the count runs out, a sticky timer flag is set, the preset is reloaded and counting carries on. The interrupt output is the flag gated by an interrupt-enable input. The flag stays set until a clear pulse arrives. The tick pulses come from a prescaler outside this block and must be single-cycle enables in the block's clock domain.

Top module: `cdt_timer`

## Requirements
- R1: After reset, `count_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: A write with `wr_hi_i`=0 sets preset bits 7:0 from `wr_data_i[7:0]`. A write with `wr_hi_i`=1 sets preset bits 11:8 from `wr_data_i[3:0]`, and `wr_data_i[7:4]` is ignored. While `run_en_i` is 0, `count_o` shows the updated preset in the cycle after the write.
- R3: While `run_en_i` is 0, tick pulses on any source leave `count_o` and `flag_o` unchanged.
- R4: `src_sel_i` picks the decrementing tick: 00 selects `tick_64hz_i`, 01 `tick_1hz_i`, 10 `tick_1min_i` and 11 `tick_4khz_i`. Pulses on the three unselected inputs have no effect on `count_o`.
- R5: While running, each selected tick lowers `count_o` by one. For a preset N of at least 1, `flag_o` rises in the cycle after the Nth selected tick, and not before.
- R6: On the expiring tick, `count_o` becomes the preset again and counting continues with later ticks.
- R7: `flag_o` stays set until `flag_clr_i` is pulsed. If expiry and `flag_clr_i` fall in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is high.
- R9: With a preset of 0, running never sets `flag_o`, and `count_o` stays 0.
- R10: A preset write while running changes only the preset. `count_o` keeps its value, and the new preset is used at the next reload.
- R11: Clearing `run_en_i` holds `count_o`. Setting it again resumes counting from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_64hz_i | input | 1 | 64 Hz tick enable (source code 00) |
| tick_1hz_i | input | 1 | 1 Hz tick enable (source code 01) |
| tick_1min_i | input | 1 | Once-per-minute tick enable (source code 10) |
| tick_4khz_i | input | 1 | 4096 Hz tick enable (source code 11) |
| src_sel_i | input | 2 | Tick source select |
| run_en_i | input | 1 | Count enable |
| irq_en_i | input | 1 | Interrupt enable |
| wr_en_i | input | 1 | Preset write strobe |
| wr_hi_i | input | 1 | 0: low preset byte, 1: high preset nibble |
| wr_data_i | input | 8 | Write data |
| flag_clr_i | input | 1 | Clears the timer flag |
| count_o | output | 12 | Current count |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The count is visible on `count_o`, so a wrong decrement, a decrement on the wrong source, or a missed hold shows up one cycle after the tick that caused it. A bad reload or an early or late expiry shows up on `flag_o` and `count_o` in the cycle after the Nth tick. A corrupted preset half is not visible until the next load while stopped, or until the next reload while running. The sweep covers every source code against several presets, and adds the two extremes (0 and 4095).

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned CDT_CNT_W = 12;
    localparam int unsigned CDT_LO_W  = 8;
    localparam int unsigned CDT_NSRC  = 4;

    // Source codes; the tick vector is packed so that bit index == code.
    typedef enum logic [1:0] {
        SRC_64HZ = 2'b00,
        SRC_1HZ  = 2'b01,
        SRC_1MIN = 2'b10,
        SRC_4KHZ = 2'b11
    } src_e;

endpackage

// File: rtl/cdt_preset_regs.sv
module cdt_preset_regs #(
    parameter int unsigned CNT_W = cdt_pkg::CDT_CNT_W,
    parameter int unsigned LO_W  = cdt_pkg::CDT_LO_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_hi_i,
    input  logic [LO_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0] preset_nx_o,
    output logic             load_o
);
    localparam int unsigned HI_W = CNT_W - LO_W;

    logic [CNT_W-1:0] preset_d, preset_q;

    always_comb begin
        preset_d = preset_q;
        if (wr_en_i) begin
            if (wr_hi_i) begin
                preset_d[CNT_W-1:LO_W] = wr_data_i[HI_W-1:0];
            end else begin
                preset_d[LO_W-1:0] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            preset_q <= '0;
        end else begin
            preset_q <= preset_d;
        end
    end

    // Merged value: the newest preset, including a write in this cycle.
    assign preset_nx_o = preset_d;
    assign load_o      = wr_en_i;

endmodule

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel #(
    parameter int unsigned NSRC  = cdt_pkg::CDT_NSRC,
    parameter int unsigned SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  ticks_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = ticks_i[g] & (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/cdt_count_core.sv
module cdt_count_core #(
    parameter int unsigned CNT_W = cdt_pkg::CDT_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] preset_nx_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_t;

    core_t st_d, st_q;
    logic  expire;

    always_comb begin
        st_d   = st_q;
        expire = run_i & tick_i & (st_q.cnt == CNT_W'(1));
        if (!run_i) begin
            if (load_i) begin
                st_d.cnt = preset_nx_i;
            end
        end else if (tick_i) begin
            if (expire) begin
                st_d.cnt = preset_nx_i;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int unsigned CNT_W = cdt_pkg::CDT_CNT_W,
    parameter int unsigned LO_W  = cdt_pkg::CDT_LO_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_64hz_i,
    input  logic             tick_1hz_i,
    input  logic             tick_1min_i,
    input  logic             tick_4khz_i,
    input  logic [1:0]       src_sel_i,
    input  logic             run_en_i,
    input  logic             irq_en_i,
    input  logic             wr_en_i,
    input  logic             wr_hi_i,
    input  logic [LO_W-1:0]  wr_data_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam int unsigned NSRC  = cdt_pkg::CDT_NSRC;
    localparam int unsigned SEL_W = $clog2(NSRC);

    logic [NSRC-1:0]  ticks;
    logic             tick_sel;
    logic [CNT_W-1:0] preset_nx;
    logic             load;

    // Bit index equals the source code.
    assign ticks = {tick_4khz_i, tick_1min_i, tick_1hz_i, tick_64hz_i};

    cdt_tick_sel #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) i_tick_sel (
        .ticks_i (ticks),
        .sel_i   (src_sel_i),
        .tick_o  (tick_sel)
    );

    cdt_preset_regs #(
        .CNT_W (CNT_W),
        .LO_W  (LO_W)
    ) i_preset_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_hi_i     (wr_hi_i),
        .wr_data_i   (wr_data_i),
        .preset_nx_o (preset_nx),
        .load_o      (load)
    );

    cdt_count_core #(
        .CNT_W (CNT_W)
    ) i_count_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (run_en_i),
        .tick_i      (tick_sel),
        .load_i      (load),
        .preset_nx_i (preset_nx),
        .flag_clr_i  (flag_clr_i),
        .cnt_o       (count_o),
        .flag_o      (flag_o)
    );

    assign irq_o = flag_o & irq_en_i;

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int unsigned CNT_W = cdt_pkg::CDT_CNT_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_64hz_i,
    input logic             tick_1hz_i,
    input logic             tick_1min_i,
    input logic             tick_4khz_i,
    input logic [1:0]       src_sel_i,
    input logic             run_en_i,
    input logic             irq_en_i,
    input logic             wr_en_i,
    input logic             flag_clr_i,
    input logic [CNT_W-1:0] count_o,
    input logic             flag_o,
    input logic             irq_o
);
    logic chosen;

    always_comb begin
        case (src_sel_i)
            2'b00:   chosen = tick_64hz_i;
            2'b01:   chosen = tick_1hz_i;
            2'b10:   chosen = tick_1min_i;
            default: chosen = tick_4khz_i;
        endcase
    end

    a_r3_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_en_i && !wr_en_i) |=> $stable(count_o));

    a_r4_no_tick_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_i && !chosen) |=> $stable(count_o));

    a_r5_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_i && chosen && count_o > CNT_W'(1)) |=> (count_o == $past(count_o) - CNT_W'(1)));

    a_r5_expiry_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_i && chosen && count_o == CNT_W'(1)) |=> flag_o);

    a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o);

    a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag_o && irq_en_i));

    a_r9_zero_never_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == '0 && !flag_o) |=> !flag_o);

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) i_cdt_timer_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_64hz_i (tick_64hz_i),
    .tick_1hz_i  (tick_1hz_i),
    .tick_1min_i (tick_1min_i),
    .tick_4khz_i (tick_4khz_i),
    .src_sel_i   (src_sel_i),
    .run_en_i    (run_en_i),
    .irq_en_i    (irq_en_i),
    .wr_en_i     (wr_en_i),
    .flag_clr_i  (flag_clr_i),
    .count_o     (count_o),
    .flag_o      (flag_o),
    .irq_o       (irq_o)
);

// File: tb/test_cdt_timer.sv
module test_cdt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tk = 4'b0;
    logic [1:0]  sel = 2'b00;
    logic        run = 1'b0;
    logic        ien = 1'b0;
    logic        wr = 1'b0;
    logic        whi = 1'b0;
    logic [7:0]  wdat = 8'h00;
    logic        fclr = 1'b0;
    logic [11:0] count;
    logic        flag;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cdt_timer i_cdt_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_64hz_i (tk[0]),
        .tick_1hz_i  (tk[1]),
        .tick_1min_i (tk[2]),
        .tick_4khz_i (tk[3]),
        .src_sel_i   (sel),
        .run_en_i    (run),
        .irq_en_i    (ien),
        .wr_en_i     (wr),
        .wr_hi_i     (whi),
        .wr_data_i   (wdat),
        .flag_clr_i  (fclr),
        .count_o     (count),
        .flag_o      (flag),
        .irq_o       (irq)
    );

    // Inputs change 1 ns after a rising edge; results are sampled there too.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(bit hi, logic [7:0] d);
        wr = 1'b1; whi = hi; wdat = d;
        cyc();
        wr = 1'b0;
    endtask

    task automatic load(int p);
        wr_reg(1'b0, 8'(p));
        wr_reg(1'b1, 8'(p >> 8));
    endtask

    task automatic clear_flag();
        fclr = 1'b1;
        cyc();
        fclr = 1'b0;
    endtask

    task automatic pulse_sel(int n);
        for (int i = 0; i < n; i++) begin
            tk = 4'b1 << sel;
            cyc();
            tk = 4'b0;
            cyc();
        end
    endtask

    task automatic pulse_others(int n);
        for (int i = 0; i < n; i++) begin
            tk = ~(4'b1 << sel);
            cyc();
            tk = 4'b0;
            cyc();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int presets[6] = '{1, 2, 3, 5, 9, 17};
        ien = 1'b1;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1
        chk("R1 count", count, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        ien = 1'b0;

        // R2: byte split, upper data bits of the high write ignored
        wr_reg(1'b0, 8'hA5);
        chk("R2 low byte", count, 12'h0A5);
        wr_reg(1'b1, 8'hF3);
        chk("R2 high nibble", count, 12'h3A5);

        // R3: stopped, all ticks ignored
        tk = 4'hF; cyc(); tk = 4'h0; cyc();
        tk = 4'hF; cyc(); tk = 4'h0; cyc();
        chk("R3 hold count", count, 12'h3A5);
        chk("R3 no flag", flag, 0);

        // Sweep every source code against several presets
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 6; k++) begin
                int p = presets[k];
                run = 1'b0; ien = 1'b0;
                clear_flag();
                sel = 2'(s);
                load(p);
                chk("R2 load", count, p);
                run = 1'b1;
                pulse_others(3);
                chk("R4 unselected ignored", count, p);
                pulse_sel(p - 1);
                chk("R5 count before expiry", count, 1);
                chk("R5 no early flag", flag, 0);
                pulse_sel(1);
                chk("R5 flag on Nth tick", flag, 1);
                chk("R6 reload", count, p);
                chk("R8 irq masked", irq, 0);
                ien = 1'b1;
                cyc();
                chk("R8 irq enabled", irq, 1);
                if (p > 1) begin
                    pulse_sel(1);
                    chk("R6 counting continues", count, p - 1);
                end
                chk("R7 flag sticky", flag, 1);
                clear_flag();
                chk("R7 flag cleared", flag, 0);
                chk("R8 irq follows flag", irq, 0);
            end
        end

        // R5 extremes: 4095 on 4096 Hz, 320 on 64 Hz, ticks held high
        run = 1'b0; ien = 1'b0; clear_flag();
        sel = 2'b11; load(4095); run = 1'b1;
        tk = 4'b1000;
        repeat (4094) cyc();
        chk("R5 4095 not yet", flag, 0);
        chk("R5 4095 count", count, 1);
        cyc();
        tk = 4'b0;
        chk("R5 4095 expired", flag, 1);
        chk("R6 4095 reload", count, 4095);

        run = 1'b0; clear_flag();
        sel = 2'b00; load(320); run = 1'b1;
        tk = 4'b0001;
        repeat (319) cyc();
        chk("R5 320 not yet", flag, 0);
        cyc();
        tk = 4'b0;
        chk("R5 320 expired", flag, 1);

        // R9: zero preset
        run = 1'b0; clear_flag();
        sel = 2'b01; load(0); run = 1'b1;
        pulse_sel(10);
        chk("R9 no flag", flag, 0);
        chk("R9 count zero", count, 0);

        // R10: write while running
        run = 1'b0; clear_flag();
        load(6); run = 1'b1;
        pulse_sel(2);
        chk("R10 before write", count, 4);
        wr_reg(1'b0, 8'd3);
        chk("R10 count kept", count, 4);
        pulse_sel(3);
        chk("R10 count down", count, 1);
        chk("R10 no flag yet", flag, 0);
        pulse_sel(1);
        chk("R10 flag", flag, 1);
        chk("R10 new preset reload", count, 3);

        // R11: hold and resume
        run = 1'b0; clear_flag();
        sel = 2'b10; load(10); run = 1'b1;
        pulse_sel(3);
        chk("R11 running", count, 7);
        run = 1'b0;
        pulse_sel(5);
        pulse_others(2);
        chk("R11 held", count, 7);
        run = 1'b1;
        pulse_sel(6);
        chk("R11 resumed", count, 1);
        pulse_sel(1);
        chk("R11 expiry after resume", flag, 1);

        // R7: set wins over clear in the same cycle
        run = 1'b0; clear_flag();
        load(2); run = 1'b1;
        pulse_sel(1);
        chk("R7 primed", count, 1);
        tk = 4'b1 << sel; fclr = 1'b1;
        cyc();
        tk = 4'b0; fclr = 1'b0;
        chk("R7 set wins", flag, 1);
        repeat (20) cyc();
        chk("R7 still set", flag, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule